// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for 16-bit fixed-point work. A small bank of operand registers is loaded through a write port. Each cycle an operation code can pick two of these registers, multiply them as signed, mixed or unsigned values, and either load the product into one of two wide accumulators or add it to, or subtract it from, that accumulator's current value. The accumulators are 40 bits wide: the 32-bit product plus eight guard bits, so long sums can run without wrapping.

Two format controls shape each operation. A fractional control doubles the product, which suits signed fractional data. A rounding control rounds the new accumulator value to its upper part, discarding the low 16 bits. A mode bit selects plain round-half-up or round-half-to-even for exact ties. An overflow flag reports whether the last updating operation left the signed 40-bit range.

The accumulators update on the clock edge that samples the operation and are visible on the read ports straight after that edge.

Top module: `mac_unit`

## Requirements
- R1: While reset is high, both accumulators read zero and the overflow flag is low.
- R2: With the write enable high, the operand register named by the 2-bit write index takes the write data at the clock edge. The two 2-bit operand selects pick the X and Y registers that an operation reads.
- R3: Each updating operation sets the overflow flag when its exact result, after rounding, lies outside -2^39 .. 2^39-1, and clears the flag otherwise. Operation code 0 leaves the flag unchanged.
- R4: Sign mode 0 treats X and Y as signed. Mode 1 treats X as signed and Y as unsigned. Modes 2 and 3 treat both as unsigned. The product is extended to 40 bits as a signed value.
- R5: Operation codes: 0 hold, 1 load the product, 2 add the product, 3 subtract the product. Only the accumulator picked by the accumulator select changes. Code 0 changes neither accumulator.
- R6: With the fractional control high, the product is shifted left by one bit before it is used.
- R7: With the rounding control high and the mode bit low, 0x8000 is added to the result and bits 15..0 are cleared.
- R8: With the rounding control high and the mode bit high, rounding is done as in R7. When the discarded bits 15..0 were exactly 0x8000, bit 16 of the stored value is also cleared.
- R9: The read ports show all 40 bits of each accumulator. The new value appears after the clock edge that samples the operation.
- R10: Adding and subtracting wrap modulo 2^40 in the stored accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Operand register write enable |
| wr_idx | input | 2 | Operand register to write |
| wr_data | input | 16 | Operand write data |
| op | input | 2 | Operation code (0 hold, 1 load, 2 add, 3 subtract) |
| acc_sel | input | 1 | Target accumulator |
| x_sel | input | 2 | X operand register select |
| y_sel | input | 2 | Y operand register select |
| sign_mode | input | 2 | Operand signedness (0 SS, 1 SU, 2/3 UU) |
| frac_en | input | 1 | Double the product (fractional format) |
| rnd_en | input | 1 | Round the result to its upper part |
| rnd_conv | input | 1 | Rounding mode: 0 half-up, 1 half-to-even |
| acc_o | output | 2x40 | Accumulator read ports, index = accumulator |
| ovf_o | output | 1 | Overflow of the last updating operation |

## Verification
The bench builds the block with its default parameters: 16-bit operands, eight guard bits, four operand registers and two accumulators. These values keep the largest doubled unsigned product near 2^33. A run of about 64 accumulations therefore reaches the 40-bit overflow and wrap boundary, which the bench drives in both directions. With 16-bit operands, exact rounding ties at 0x8000 can be built directly from small multiplicands. This lets the bench test both parities of bit 16 under both rounding modes.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    SG_SS  = 2'd0,
    SG_SU  = 2'd1,
    SG_UU  = 2'd2,
    SG_UU3 = 2'd3
  } sign_mode_e;

endpackage

// File: rtl/mac_opregs.sv
module mac_opregs #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [SELW-1:0] x_sel,
  input  logic [SELW-1:0] y_sel,
  output logic [DW-1:0]   x_val,
  output logic [DW-1:0]   y_val
);

  logic [DW-1:0] opr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_opr
    always_ff @(posedge clk) begin
      if (rst)
        opr_q[g] <= '0;
      else if (wr_en && (wr_idx == SELW'(g)))
        opr_q[g] <= wr_data;
    end
  end

  assign x_val = opr_q[x_sel];
  assign y_val = opr_q[y_sel];

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  input  logic [1:0]    sign_mode,
  input  logic          frac_en,
  output logic [AW-1:0] prod
);

  localparam int PEW = 2*DW + 2;

  // Widen each operand by one bit so a single signed multiply covers all modes.
  function automatic logic [AW-1:0] ext_product(input logic [DW-1:0] x,
                                                input logic [DW-1:0] y,
                                                input logic [1:0]    mode);
    logic signed [DW:0]    xw;
    logic signed [DW:0]    yw;
    logic signed [PEW-1:0] pw;
    xw = {((mode == 2'd0) || (mode == 2'd1)) & x[DW-1], x};
    yw = {(mode == 2'd0) & y[DW-1], y};
    pw = xw * yw;
    return {{(AW-PEW){pw[PEW-1]}}, pw};
  endfunction

  logic [AW-1:0] raw_prod;

  assign raw_prod = ext_product(x_val, y_val, sign_mode);
  assign prod     = frac_en ? {raw_prod[AW-2:0], 1'b0} : raw_prod;

endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [AW:0] sum_in,
  input  logic        rnd_en,
  input  logic        rnd_conv,
  output logic [AW:0] res_out,
  output logic        tie_hit
);

  localparam logic [AW:0] HALF = (AW+1)'(1) << (DW-1);

  function automatic logic [AW:0] round_val(input logic [AW:0] v,
                                            input logic        conv);
    logic [AW:0] r;
    r = v + HALF;
    r[DW-1:0] = '0;
    if (conv && (v[DW-1:0] == HALF[DW-1:0]))
      r[DW] = 1'b0;
    return r;
  endfunction

  assign tie_hit = rnd_en && (sum_in[DW-1:0] == HALF[DW-1:0]);
  assign res_out = rnd_en ? round_val(sum_in, rnd_conv) : sum_in;

endmodule

// File: rtl/mac_accbank.sv
module mac_accbank #(
  parameter int AW   = 40,
  parameter int NACC = 2,
  localparam int ASW = $clog2(NACC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_en,
  input  logic [ASW-1:0]            acc_sel,
  input  logic [AW-1:0]             acc_next,
  input  logic                      ovf_now,
  output logic [NACC-1:0][AW-1:0]   acc_q,
  output logic                      ovf_q
);

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[g] <= '0;
      else if (upd_en && (acc_sel == ASW'(g)))
        acc_q[g] <= acc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovf_q <= 1'b0;
    else if (upd_en)
      ovf_q <= ovf_now;
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 8,
  parameter int NREG  = 4,
  parameter int NACC  = 2,
  localparam int AW   = 2*DW + GUARD,
  localparam int SELW = $clog2(NREG),
  localparam int ASW  = $clog2(NACC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SELW-1:0]         wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [1:0]              op,
  input  logic [ASW-1:0]          acc_sel,
  input  logic [SELW-1:0]         x_sel,
  input  logic [SELW-1:0]         y_sel,
  input  logic [1:0]              sign_mode,
  input  logic                    frac_en,
  input  logic                    rnd_en,
  input  logic                    rnd_conv,
  output logic [NACC-1:0][AW-1:0] acc_o,
  output logic                    ovf_o
);

  logic [DW-1:0] x_val;
  logic [DW-1:0] y_val;
  logic [AW-1:0] prod;
  logic [AW-1:0] acc_cur;
  logic [AW:0]   sum_w;
  logic [AW:0]   res_w;
  logic          tie_hit;
  logic          upd_en;
  logic          ovf_now;
  mac_op_e       op_e;

  mac_opregs #(.DW(DW), .NREG(NREG)) u_opregs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .x_sel   (x_sel),
    .y_sel   (y_sel),
    .x_val   (x_val),
    .y_val   (y_val)
  );

  mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .x_val     (x_val),
    .y_val     (y_val),
    .sign_mode (sign_mode),
    .frac_en   (frac_en),
    .prod      (prod)
  );

  // One extra bit keeps the exact signed sum so overflow can be judged afterwards.
  function automatic logic [AW:0] combine(input mac_op_e       code,
                                          input logic [AW-1:0] a,
                                          input logic [AW-1:0] p);
    logic [AW:0] ax;
    logic [AW:0] px;
    ax = {a[AW-1], a};
    px = {p[AW-1], p};
    case (code)
      OP_LOAD: return px;
      OP_ADD:  return ax + px;
      OP_SUB:  return ax - px;
      default: return ax;
    endcase
  endfunction

  assign op_e    = mac_op_e'(op);
  assign acc_cur = acc_o[acc_sel];
  assign sum_w   = combine(op_e, acc_cur, prod);
  assign upd_en  = (op_e != OP_HOLD);

  mac_round #(.DW(DW), .AW(AW)) u_round (
    .sum_in   (sum_w),
    .rnd_en   (rnd_en),
    .rnd_conv (rnd_conv),
    .res_out  (res_w),
    .tie_hit  (tie_hit)
  );

  assign ovf_now = res_w[AW] ^ res_w[AW-1];

  mac_accbank #(.AW(AW), .NACC(NACC)) u_accbank (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .acc_sel  (acc_sel),
    .acc_next (res_w[AW-1:0]),
    .ovf_now  (ovf_now),
    .acc_q    (acc_o),
    .ovf_q    (ovf_o)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW   = 16,
  parameter int AW   = 40,
  parameter int NACC = 2,
  localparam int ASW = $clog2(NACC)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    upd_en,
  input logic [ASW-1:0]          acc_sel,
  input logic                    rnd_en,
  input logic                    rnd_conv,
  input logic                    tie_hit,
  input logic [NACC-1:0][AW-1:0] acc_o,
  input logic                    ovf_o
);

  logic [ASW-1:0] sel_q;
  always_ff @(posedge clk) sel_q <= acc_sel;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_o == '0) && !ovf_o);

  assert_hold_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(ovf_o));

  assert_hold_acc_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(acc_o));

  for (genvar g = 0; g < NACC; g++) begin : g_other
    assert_other_acc_R5: assert property (@(posedge clk) disable iff (rst)
      (upd_en && (acc_sel != ASW'(g))) |=> $stable(acc_o[g]));
  end

  assert_round_low_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && rnd_en) |=> (acc_o[sel_q][DW-1:0] == '0));

  assert_conv_even_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && tie_hit && rnd_conv) |=> !acc_o[sel_q][DW]);

endmodule

bind mac_unit mac_unit_chk #(.DW(DW), .AW(AW), .NACC(NACC)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .upd_en   (upd_en),
  .acc_sel  (acc_sel),
  .rnd_en   (rnd_en),
  .rnd_conv (rnd_conv),
  .tie_hit  (tie_hit),
  .acc_o    (acc_o),
  .ovf_o    (ovf_o)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_idx = '0;
  logic [15:0]      wr_data = '0;
  logic [1:0]       op = '0;
  logic             acc_sel = 1'b0;
  logic [1:0]       x_sel = '0;
  logic [1:0]       y_sel = '0;
  logic [1:0]       sign_mode = '0;
  logic             frac_en = 1'b0;
  logic             rnd_en = 1'b0;
  logic             rnd_conv = 1'b0;
  logic [1:0][39:0] acc_o;
  logic             ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [4];
  logic [39:0] m_acc [2];
  logic        m_ovf;

  always #4 clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .op(op), .acc_sel(acc_sel), .x_sel(x_sel), .y_sel(y_sel),
    .sign_mode(sign_mode), .frac_en(frac_en), .rnd_en(rnd_en),
    .rnd_conv(rnd_conv), .acc_o(acc_o), .ovf_o(ovf_o)
  );

  function automatic longint as_signed40(logic [39:0] a);
    longint v = longint'(a);
    if (a[39]) v = v - (64'sd1 <<< 40);
    return v;
  endfunction

  function automatic longint ref_product(logic [15:0] x, logic [15:0] y,
                                         logic [1:0] mode, logic frac);
    longint xv = longint'(x);
    longint yv = longint'(y);
    longint p;
    if (mode < 2'd2 && x[15]) xv = xv - 65536;
    if (mode == 2'd0 && y[15]) yv = yv - 65536;
    p = xv * yv;
    if (frac) p = p * 2;
    return p;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(acc_o[0] == m_acc[0], req, "acc0", longint'(acc_o[0]), longint'(m_acc[0]));
    check(acc_o[1] == m_acc[1], req, "acc1", longint'(acc_o[1]), longint'(m_acc[1]));
    check(ovf_o == m_ovf, req, "ovf", longint'(ovf_o), longint'(m_ovf));
  endtask

  task automatic write_reg(logic [1:0] idx, logic [15:0] val, string req);
    wr_en = 1'b1; wr_idx = idx; wr_data = val; op = 2'd0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_reg[idx] = val;
    compare_all(req);
  endtask

  task automatic do_op(logic [1:0] code, logic sel, logic [1:0] xs, logic [1:0] ys,
                       logic [1:0] mode, logic frac, logic rnd, logic conv, string req);
    longint a = as_signed40(m_acc[sel]);
    longint p = ref_product(m_reg[xs], m_reg[ys], mode, frac);
    longint e;
    longint low;
    op = code; acc_sel = sel; x_sel = xs; y_sel = ys;
    sign_mode = mode; frac_en = frac; rnd_en = rnd; rnd_conv = conv;
    @(posedge clk); #1;
    op = 2'd0;
    if (code != 2'd0) begin
      case (code)
        2'd1: e = p;
        2'd2: e = a + p;
        default: e = a - p;
      endcase
      if (rnd) begin
        low = e & 64'hFFFF;
        e = (e + 32768) & ~64'hFFFF;
        if (conv && low == 32768) e = e & ~64'h10000;
      end
      m_ovf = (e > 64'sh7F_FFFF_FFFF) || (e < -64'sh80_0000_0000);
      m_acc[sel] = e[39:0];
    end
    compare_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_acc[0] = '0; m_acc[1] = '0; m_ovf = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    rst = 1'b0;

    // R2 R4 R6: most negative squared in signed fractional form
    write_reg(2'd0, 16'h8000, "R2 write");
    write_reg(2'd1, 16'h8000, "R2 write");
    do_op(2'd1, 1'b0, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, "R6 R4 SS frac load");
    check(acc_o[0] == 40'h00_8000_0000, "R6", "frac corner", longint'(acc_o[0]), 64'h80000000);

    // R4: signedness codes on all-ones operands
    write_reg(2'd2, 16'hFFFF, "R2 write");
    write_reg(2'd3, 16'hFFFF, "R2 write");
    do_op(2'd1, 1'b1, 2'd2, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, "R4 UU load");
    check(acc_o[1] == 40'h00_FFFE_0001, "R4", "UU product", longint'(acc_o[1]), 64'hFFFE0001);
    do_op(2'd1, 1'b1, 2'd2, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, "R4 SU load");
    check(acc_o[1] == 40'hFF_FFFF_0001, "R4", "SU product", longint'(acc_o[1]), 64'hFFFFFF0001);
    do_op(2'd1, 1'b1, 2'd2, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, "R4 SS load");
    do_op(2'd1, 1'b1, 2'd2, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, "R4 mode3 UU");

    // R7 R8: exact ties with bit16 even and odd
    write_reg(2'd0, 16'h0001, "R2 write");
    do_op(2'd1, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, "R7 biased tie even");
    check(acc_o[0] == 40'h10000, "R7", "biased tie", longint'(acc_o[0]), 64'h10000);
    do_op(2'd1, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, "R8 conv tie even");
    check(acc_o[0] == 40'h0, "R8", "conv tie to even", longint'(acc_o[0]), 0);
    write_reg(2'd0, 16'h0003, "R2 write");
    do_op(2'd1, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, "R8 conv tie odd");
    check(acc_o[0] == 40'h20000, "R8", "conv tie up", longint'(acc_o[0]), 64'h20000);
    write_reg(2'd0, 16'h0002, "R2 write");
    do_op(2'd1, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, "R8 conv no tie");

    // R3 R10: grow past 2^39 and back with large doubled unsigned products
    do_op(2'd1, 1'b0, 2'd2, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, "R5 load");
    for (int i = 0; i < 70; i++)
      do_op(2'd2, 1'b0, 2'd2, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, "R3 R10 add wrap");
    do_op(2'd0, 1'b0, 2'd2, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, "R3 hold flag");
    for (int i = 0; i < 70; i++)
      do_op(2'd3, 1'b0, 2'd2, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, "R3 R10 sub wrap");
    check(ovf_o == m_ovf, "R3", "flag after sub run", longint'(ovf_o), longint'(m_ovf));

    // R5 R9: random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0)
        write_reg(2'($urandom_range(0, 3)), 16'($urandom()), "R2 random write");
      else
        do_op(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              "R5 R9 random op");
    end

    rst = 1'b1;
    @(posedge clk); #1;
    m_acc[0] = '0; m_acc[1] = '0; m_ovf = 1'b0;
    compare_all("R1 reset again");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule